// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. Four tester pins drive it: a test clock, a mode select, serial data in and serial data out. A sixteen-state controller steps through the standard scan sequence under the mode select. An instruction register chooses what the port does. Built in are a one-bit pass-through register and a 32-bit identification register, and the port steers whichever of them is selected toward serial data out.

The serial-out pin is launched on the falling test-clock edge. Its output enable is high only while instruction or data bits are being shifted. The port exports separate clock, shift and update strobes for the instruction path and the data path. It also exports a select line and takes a serial return input, so an external boundary-scan chain can be attached and read through the same pins. The reset input `trst_n` is sampled on the rising test-clock edge, like every other control in the block.

Top module: `jtag_tap_port`

## Requirements
- R1: From any controller state, `tms` sampled high on five rising `tck` edges in a row brings the controller to Test-Logic-Reset. Four high edges followed by a low one do not. In Test-Logic-Reset the active instruction becomes IDCODE.
- R2: `trst_n` sampled low on a rising `tck` edge forces Test-Logic-Reset. At the next falling edge `tdo_oe` is low and the IDCODE instruction is active.
- R3: `tms` and `tdi` are sampled on the rising edge of `tck`. `tdo` changes only on the falling edge.
- R4: `tdo_oe` is high exactly when the controller was in Shift-IR or Shift-DR at the most recent falling edge.
- R5: Capture-IR loads binary ...0001 into the instruction shift stage: bit 0 is 1 and all other bits are 0. Bits leave on `tdo` least significant bit first.
- R6: The instruction is 10 bits wide. 10'h000 is EXTEST and 10'h005 is SAMPLE/PRELOAD; both raise `bsr_select` and route `bsr_tdo` to `tdo`. 10'h006 is IDCODE. 10'h3FF is BYPASS. Every other code selects the bypass register.
- R7: The bypass register captures 0 in Capture-DR and delays `tdi` by exactly one shift.
- R8: With IDCODE active, Capture-DR loads the 32-bit identification value 32'h4BA06C3D. Its least significant bit is always 1, and the value shifts out least significant bit first.
- R9: With `bsr_select` high, `tdo` carries `bsr_tdo` as it was at the previous falling edge.
- R10: `ir_clock` is high in Capture-IR and Shift-IR, `ir_shift` in Shift-IR, and `ir_update` in Update-IR. `dr_clock`, `dr_shift` and `dr_update` follow the same pattern in the DR states.
- R11: The active instruction, and with it `bsr_select`, changes only at a falling edge while the controller is in Update-IR or Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising `tck` |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, launched on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad |
| ir_clock | output | 1 | Instruction path capture/shift enable |
| ir_shift | output | 1 | Instruction path shift phase |
| ir_update | output | 1 | Instruction path update phase |
| dr_clock | output | 1 | Data path capture/shift enable for the external chain |
| dr_shift | output | 1 | Data path shift phase |
| dr_update | output | 1 | Data path update phase |
| bsr_select | output | 1 | External boundary-scan chain is the selected data register |
| bsr_tdo | input | 1 | Serial return from the external chain |

## Verification
Two behaviours are hard to reach from the pins. One is the instruction change that must wait for the falling edge inside Update-IR. The bench stops an instruction scan in Exit1-IR and Pause-IR, then samples `bsr_select` between the rising and the falling edge of Update-IR. The other is the five-edge reset rule. The bench sends four high `tms` edges from inside Shift-DR and shows the controller landing in Capture-IR. It then sends five from Update-IR and reads the identification value back. A reset asserted in the middle of a chain shift is also checked, through the output enable and the next identification scan.

// File: rtl/jtag_tap_pkg.sv
// Package: shared controller state encoding and data-register selection type.
// Assumes: the 4-bit state code is private to the port; no external decoder
// depends on the numeric values.
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_EX2_DR  = 4'h0,
        ST_EX1_DR  = 4'h1,
        ST_SH_DR   = 4'h2,
        ST_PAU_DR  = 4'h3,
        ST_SEL_IR  = 4'h4,
        ST_UPD_DR  = 4'h5,
        ST_CAP_DR  = 4'h6,
        ST_SEL_DR  = 4'h7,
        ST_EX2_IR  = 4'h8,
        ST_EX1_IR  = 4'h9,
        ST_SH_IR   = 4'hA,
        ST_PAU_IR  = 4'hB,
        ST_IDLE    = 4'hC,
        ST_UPD_IR  = 4'hD,
        ST_CAP_IR  = 4'hE,
        ST_RESET   = 4'hF
    } tap_state_e;

    typedef enum logic [1:0] {
        SEL_BYPASS = 2'd0,
        SEL_IDENT  = 2'd1,
        SEL_CHAIN  = 2'd2
    } dr_sel_e;

endpackage

// File: rtl/jtag_tap_fsm.sv
// Module: sixteen-state scan controller plus the IR/DR strobe decode.
// Assumes: tms is stable around the rising tck edge; trst_n is a synchronous
// active-low reset sampled on the same edge.
module jtag_tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state,
    output logic       ir_clock,
    output logic       ir_shift,
    output logic       ir_update,
    output logic       dr_clock,
    output logic       dr_shift,
    output logic       dr_update
);

    tap_state_e state_nx;

    // Next-state table driven by the sampled mode select.
    always_comb begin
        case (state)
            ST_RESET:  state_nx = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: state_nx = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  state_nx = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: state_nx = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: state_nx = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: state_nx = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: state_nx = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  state_nx = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: state_nx = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: state_nx = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: state_nx = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: state_nx = tms ? ST_SEL_DR : ST_IDLE;
            default:   state_nx = ST_RESET;
        endcase
    end

    // State register, forced to Test-Logic-Reset by trst_n.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= state_nx;
    end

    // Strobe decode for the instruction and data paths.
    always_comb begin
        ir_clock  = (state == ST_CAP_IR) || (state == ST_SH_IR);
        ir_shift  = (state == ST_SH_IR);
        ir_update = (state == ST_UPD_IR);
        dr_clock  = (state == ST_CAP_DR) || (state == ST_SH_DR);
        dr_shift  = (state == ST_SH_DR);
        dr_update = (state == ST_UPD_DR);
    end

    // Checker-only count of consecutive high tms samples, saturating at five.
    logic [2:0] ones_run;
    always_ff @(posedge tck) begin
        if (!trst_n)          ones_run <= 3'd0;
        else if (!tms)        ones_run <= 3'd0;
        else if (ones_run < 3'd5) ones_run <= ones_run + 3'd1;
    end

    assert_five_ones_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (ones_run >= 3'd5) |-> (state == ST_RESET));

    assert_trst_forces_reset_R2: assert property (@(posedge tck)
        !trst_n |=> (state == ST_RESET));

    assert_strobes_exclusive_R10: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0({ir_shift, dr_shift, ir_update, dr_update}));

endmodule

// File: rtl/jtag_tap_ir.sv
// Module: instruction register with capture/shift stage, falling-edge
// update stage and decode into a data-register selection.
// Assumes: IR_W >= 2; the bypass code is all ones; unknown codes go to bypass.
module jtag_tap_ir
    import jtag_tap_pkg::*;
#(
    parameter int             IR_W      = 10,
    parameter logic [IR_W-1:0] OP_EXTEST = 10'h000,
    parameter logic [IR_W-1:0] OP_SAMPLE = 10'h005,
    parameter logic [IR_W-1:0] OP_IDCODE = 10'h006
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       ir_so,
    output dr_sel_e    dr_sel
);

    localparam logic [IR_W-1:0] CAP_WORD  = {{(IR_W-2){1'b0}}, 2'b01};
    localparam logic [IR_W-1:0] OP_BYPASS = '1;

    logic [IR_W-1:0] ir_sr;
    logic [IR_W-1:0] ir_q;

    // Shift stage: capture fixed pattern, then shift toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)                ir_sr <= CAP_WORD;
        else if (state == ST_CAP_IR) ir_sr <= CAP_WORD;
        else if (state == ST_SH_IR)  ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end

    // Update stage: loads on the falling edge in Update-IR, IDCODE in reset.
    always_ff @(negedge tck) begin
        if (!trst_n)                 ir_q <= OP_IDCODE;
        else if (state == ST_RESET)  ir_q <= OP_IDCODE;
        else if (state == ST_UPD_IR) ir_q <= ir_sr;
    end

    // Instruction decode; bypass covers the all-ones code and unknown codes.
    always_comb begin
        if (ir_q == OP_BYPASS)                          dr_sel = SEL_BYPASS;
        else if (ir_q == OP_IDCODE)                     dr_sel = SEL_IDENT;
        else if (ir_q == OP_SAMPLE || ir_q == OP_EXTEST) dr_sel = SEL_CHAIN;
        else                                            dr_sel = SEL_BYPASS;
    end

    assign ir_so = ir_sr[0];

    assert_capture_pattern_R5: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_IR) |=> (ir_sr == CAP_WORD));

    assert_ir_holds_R11: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_UPD_IR && state != ST_RESET) |-> $stable(ir_q));

endmodule

// File: rtl/jtag_tap_dr.sv
// Module: built-in data registers (one-bit bypass, identification word)
// and the data-path serial-out select including the external chain.
// Assumes: dr_sel is stable during a DR scan (it only changes in Update-IR).
module jtag_tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h4BA06C3D
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    input  dr_sel_e    dr_sel,
    input  logic       chain_so,
    output logic       dr_so
);

    localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

    logic            bypass_q;
    logic [ID_W-1:0] id_sr;

    // Bypass stage: zero on capture, one-bit delay on shift.
    always_ff @(posedge tck) begin
        if (!trst_n)                 bypass_q <= 1'b0;
        else if (state == ST_CAP_DR) bypass_q <= 1'b0;
        else if (state == ST_SH_DR)  bypass_q <= tdi;
    end

    // Identification stage: loads the fixed word, shifts toward bit 0.
    always_ff @(posedge tck) begin
        if (!trst_n)
            id_sr <= ID_WORD;
        else if (dr_sel == SEL_IDENT && state == ST_CAP_DR)
            id_sr <= ID_WORD;
        else if (dr_sel == SEL_IDENT && state == ST_SH_DR)
            id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    // Serial-out select for the data path.
    always_comb begin
        case (dr_sel)
            SEL_IDENT: dr_so = id_sr[0];
            SEL_CHAIN: dr_so = chain_so;
            default:   dr_so = bypass_q;
        endcase
    end

    assert_bypass_capture_R7: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR) |=> (bypass_q == 1'b0));

    assert_ident_capture_R8: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_CAP_DR && dr_sel == SEL_IDENT) |=> (id_sr[0] == 1'b1));

endmodule

// File: rtl/jtag_tap_port.sv
// Module: top of the test access port. Ties the controller, instruction
// register and data registers together and launches tdo/tdo_oe on the
// falling tck edge.
// Assumes: the tdo pad driver uses tdo_oe; the external chain shifts on
// rising tck while dr_clock and dr_shift are high and bsr_select is set.
module jtag_tap_port
    import jtag_tap_pkg::*;
#(
    parameter int              IR_W      = 10,
    parameter int              ID_W      = 32,
    parameter logic [ID_W-1:0] ID_VALUE  = 32'h4BA06C3D,
    parameter logic [IR_W-1:0] OP_EXTEST = 10'h000,
    parameter logic [IR_W-1:0] OP_SAMPLE = 10'h005,
    parameter logic [IR_W-1:0] OP_IDCODE = 10'h006
) (
    input  logic tck,
    input  logic trst_n,
    input  logic tms,
    input  logic tdi,
    output logic tdo,
    output logic tdo_oe,
    output logic ir_clock,
    output logic ir_shift,
    output logic ir_update,
    output logic dr_clock,
    output logic dr_shift,
    output logic dr_update,
    output logic bsr_select,
    input  logic bsr_tdo
);

    tap_state_e state;
    dr_sel_e    dr_sel;
    logic       ir_so;
    logic       dr_so;

    jtag_tap_fsm u_fsm (
        .tck       (tck),
        .trst_n    (trst_n),
        .tms       (tms),
        .state     (state),
        .ir_clock  (ir_clock),
        .ir_shift  (ir_shift),
        .ir_update (ir_update),
        .dr_clock  (dr_clock),
        .dr_shift  (dr_shift),
        .dr_update (dr_update)
    );

    jtag_tap_ir #(
        .IR_W      (IR_W),
        .OP_EXTEST (OP_EXTEST),
        .OP_SAMPLE (OP_SAMPLE),
        .OP_IDCODE (OP_IDCODE)
    ) u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .state  (state),
        .tdi    (tdi),
        .ir_so  (ir_so),
        .dr_sel (dr_sel)
    );

    jtag_tap_dr #(
        .ID_W     (ID_W),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck      (tck),
        .trst_n   (trst_n),
        .state    (state),
        .tdi      (tdi),
        .dr_sel   (dr_sel),
        .chain_so (bsr_tdo),
        .dr_so    (dr_so)
    );

    assign bsr_select = (dr_sel == SEL_CHAIN);

    // Falling-edge launch of serial data and its pad enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= (state == ST_SH_IR) ? ir_so : dr_so;
            tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
        end
    end

    assert_oe_only_shift_R4: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR));

    assert_oe_off_idle_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state == ST_IDLE && $past(state) == ST_IDLE) |-> !tdo_oe);

endmodule

// File: tb/jtag_tap_port_test.sv
module jtag_tap_port_test;

    localparam int          IR_W     = 10;
    localparam logic [31:0] ID_EXP   = 32'h4BA06C3D;
    localparam logic [9:0]  C_EXTEST = 10'h000;
    localparam logic [9:0]  C_SAMPLE = 10'h005;
    localparam logic [9:0]  C_BYPASS = 10'h3FF;
    localparam logic [5:0]  CHAIN_CAP = 6'b101101;

    logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
    logic tdo, tdo_oe, ir_clock, ir_shift, ir_update;
    logic dr_clock, dr_shift, dr_update, bsr_select, bsr_tdo;

    int tests = 0, fails = 0;
    bit mon_en = 1'b0;

    typedef struct { logic b; string tag; } exp_t;
    exp_t exp_q[$];

    always #5 tck = ~tck;

    jtag_tap_port uut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .tdo(tdo), .tdo_oe(tdo_oe),
        .ir_clock(ir_clock), .ir_shift(ir_shift), .ir_update(ir_update),
        .dr_clock(dr_clock), .dr_shift(dr_shift), .dr_update(dr_update),
        .bsr_select(bsr_select), .bsr_tdo(bsr_tdo)
    );

    // Bench model of a 6-cell external chain (R9).
    logic [5:0] chain = 6'b0;
    always @(posedge tck)
        if (dr_clock && bsr_select)
            chain <= dr_shift ? {tdi, chain[5:1]} : CHAIN_CAP;
    assign bsr_tdo = chain[0];

    // Monitor: pops one expected bit per shifting rising edge.
    always @(posedge tck) begin
        if (mon_en) begin
            tests++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL scoreboard empty: tdo=%b expected nothing", tdo);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (tdo !== e.b || tdo_oe !== 1'b1) begin
                    fails++;
                    $display("FAIL %s tdo=%b oe=%b expected tdo=%b oe=1", e.tag, tdo, tdo_oe, e.b);
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic push(input logic b, input string tag);
        exp_t e;
        e.b = b; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic step(input logic m, input logic d);
        tms = m; tdi = d;
        @(posedge tck); @(negedge tck); #1;
    endtask

    // Driver: IR scan from Run-Test/Idle back to Run-Test/Idle.
    task automatic ir_scan(input logic [9:0] code);
        for (int i = 0; i < IR_W; i++) push(i == 0, "R5 capture pattern");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        mon_en = 1'b1;
        for (int i = 0; i < IR_W; i++) step(i == IR_W - 1, code[i]);
        mon_en = 1'b0;
        step(1, 0); step(0, 0);
    endtask

    // Driver: DR scan of n bits; the caller pushes the expected bits.
    task automatic dr_scan(input int n, input logic [31:0] data);
        step(1, 0); step(0, 0); step(0, 0);
        mon_en = 1'b1;
        for (int i = 0; i < n; i++) step(i == n - 1, data[i]);
        mon_en = 1'b0;
        step(1, 0); step(0, 0);
    endtask

    task automatic push_id(input string tag);
        for (int i = 0; i < 32; i++) push(ID_EXP[i], tag);
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge tck); #1;
        step(1, 0); step(1, 0); step(1, 0);
        chk("R2 reset oe", {31'b0, tdo_oe}, 32'd0);
        chk("R10 reset strobes", {26'b0, ir_clock, ir_shift, ir_update, dr_clock, dr_shift, dr_update}, 32'd0);
        chk("R2 reset select", {31'b0, bsr_select}, 32'd0);
        trst_n = 1'b1;
        step(0, 0);
        chk("R4 idle oe", {31'b0, tdo_oe}, 32'd0);

        // Reset instruction is IDCODE (R1, R8).
        push_id("R8 idcode after reset");
        dr_scan(32, 32'h0);

        // Strobes across a DR pass (R10, R4).
        step(1, 0);
        chk("R10 select-dr strobes", {30'b0, dr_clock, dr_shift}, 32'd0);
        step(0, 0);
        chk("R10 capture-dr strobes", {30'b0, dr_clock, dr_shift}, 32'd2);
        step(0, 0);
        chk("R10 shift-dr strobes", {29'b0, dr_clock, dr_shift, tdo_oe}, 32'd7);
        step(1, 0);
        chk("R4 exit1 oe", {30'b0, dr_shift, tdo_oe}, 32'd0);
        step(1, 0);
        chk("R10 update-dr strobe", {31'b0, dr_update}, 32'd1);
        step(0, 0);

        // Instruction change only at falling edge of Update-IR (R11, R3).
        for (int i = 0; i < IR_W; i++) push(i == 0, "R5 capture pattern");
        step(1, 0); step(1, 0); step(0, 0);
        chk("R10 capture-ir strobes", {30'b0, ir_clock, ir_shift}, 32'd2);
        step(0, 0);
        chk("R10 shift-ir strobes", {30'b0, ir_clock, ir_shift}, 32'd3);
        mon_en = 1'b1;
        for (int i = 0; i < IR_W; i++) step(i == IR_W - 1, C_SAMPLE[i]);
        mon_en = 1'b0;
        chk("R11 exit1-ir select", {31'b0, bsr_select}, 32'd0);
        step(0, 0);
        chk("R11 pause-ir select", {31'b0, bsr_select}, 32'd0);
        step(1, 0);
        tms = 1'b1; @(posedge tck); #1;
        chk("R10 update-ir strobe", {31'b0, ir_update}, 32'd1);
        chk("R11 before falling edge", {31'b0, bsr_select}, 32'd0);
        @(negedge tck); #1;
        chk("R11 after falling edge", {31'b0, bsr_select}, 32'd1);
        step(0, 0);

        // External chain data through tdo (R9, R6 SAMPLE).
        for (int i = 0; i < 6; i++) push(CHAIN_CAP[i], "R9 chain capture");
        dr_scan(6, 32'h2A);

        ir_scan(C_EXTEST);
        chk("R6 extest selects chain", {31'b0, bsr_select}, 32'd1);

        // Unknown code acts as bypass (R6, R7): data 1011 -> 0,1,1,0.
        ir_scan(10'h155);
        chk("R6 unknown deselects chain", {31'b0, bsr_select}, 32'd0);
        push(0, "R6 unknown->bypass"); push(1, "R6 unknown->bypass");
        push(1, "R6 unknown->bypass"); push(0, "R6 unknown->bypass");
        dr_scan(4, 32'hB);

        // All-ones bypass with 8 bits: 0 then d0..d6 (R7).
        ir_scan(C_BYPASS);
        push(0, "R7 bypass first bit");
        for (int i = 0; i < 7; i++) push(8'hC5 >> i, "R7 bypass delay");
        dr_scan(8, 32'hC5);

        // TDO launched on falling edge only (R3).
        step(1, 0); step(0, 0); step(0, 0);
        tms = 1'b0; tdi = 1'b1;
        @(posedge tck); #1;
        chk("R3 tdo held past rising edge", {31'b0, tdo}, 32'd0);
        @(negedge tck); #1;
        chk("R7 tdo after falling edge", {31'b0, tdo}, 32'd1);
        // Four ones from Shift-DR do not reset (R1).
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(0, 0);
        chk("R1 four ones land in capture-ir", {30'b0, ir_clock, ir_shift}, 32'd2);
        step(1, 0); step(1, 0);
        // Five ones from Update-IR reset (R1).
        step(1, 0); step(1, 0); step(1, 0); step(1, 0); step(1, 0);
        chk("R1 five ones oe", {31'b0, tdo_oe}, 32'd0);
        step(0, 0);
        push_id("R1 idcode after five ones");
        dr_scan(32, 32'h0);

        // Reset in mid chain shift (R2).
        ir_scan(C_SAMPLE);
        step(1, 0); step(0, 0); step(0, 0);
        chk("R4 shift-dr oe", {31'b0, tdo_oe}, 32'd1);
        trst_n = 1'b0;
        step(0, 0);
        trst_n = 1'b1;
        chk("R2 oe after trst", {31'b0, tdo_oe}, 32'd0);
        chk("R2 select after trst", {31'b0, bsr_select}, 32'd0);
        step(0, 0);
        push_id("R2 idcode after trst");
        dr_scan(32, 32'h0);

        chk("scoreboard drained", exp_q.size(), 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule